// File: doc/BRIEF.md
# Register-to-Register Fetch-Execute Datapath

A single-cycle datapath that reads one 32-bit instruction per clock from a small instruction store. The store is addressed by a word-aligned program counter. The datapath decodes the register-to-register format and performs an add, a subtract or a bitwise OR on two source registers. It writes the result back into a 32-entry, 32-bit register file in the same cycle. The program counter steps by four on every clock in which the core is allowed to run.

Before a program starts, the core is held idle with `run_i` low. A preload port then fills the instruction store and seeds the register file. Once `run_i` is raised, every clock retires exactly one instruction. The write-back bus (`wb_en_o`, `wb_rd_o`, `wb_data_o`) shows the instruction that commits at the next rising edge, and `pc_o` shows its address.

Top module: `rtype_core`

## Requirements
- R1: Reset is asynchronous and active low, and its release is synchronized to the clock. After reset the program counter reads 0, every register reads 0, and `wb_en_o` is low while `run_i` is low.
- R2: On each rising edge with `run_i` high, the program counter increases by 4, wrapping modulo 2^32. With `run_i` low it holds its value and `wb_en_o` stays low.
- R3: The instruction is fetched from the store word at index `pc[AW+1:2]`, where AW = log2(IMEM_DEPTH). Higher PC bits are ignored, so the program repeats after IMEM_DEPTH instructions. The low two PC bits are always 00.
- R4: Instruction fields, from bit 31 down, are: op [31:26], rs [25:21], rt [20:16], rd [15:11], shamt [10:6], func [5:0]. With op = 0 and func = 0x21, R[rd] receives R[rs] + R[rt], wrapping modulo 2^32 with no overflow signal.
- R5: With op = 0 and func = 0x23, R[rd] receives R[rs] - R[rt], wrapping modulo 2^32.
- R6: With op = 0 and func = 0x25, R[rd] receives R[rs] | R[rt].
- R7: Any other op or func value drives `wb_en_o` low and changes no register. The program counter still advances.
- R8: Register 0 always reads as zero. A committed instruction with rd = 0 still shows its result on the write-back bus, but it leaves register 0 at zero.
- R9: The shamt field has no effect on any of the three operations.
- R10: While `run_i` is low, a cycle with `ld_en_i` high writes `ld_data_i`. If `ld_reg_i` is 1, it goes into the register whose index is `ld_addr_i[4:0]`; a load to register 0 is ignored. If `ld_reg_i` is 0, it goes into the instruction store word at `ld_addr_i`.
- R11: Source registers are read combinationally. An instruction therefore sees the result written by the instruction just before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Clock enable for execution; preload is allowed while low |
| ld_en_i | input | 1 | Preload write strobe |
| ld_reg_i | input | 1 | Preload target: 1 = register file, 0 = instruction store |
| ld_addr_i | input | AW | Preload index |
| ld_data_i | input | 32 | Preload data |
| pc_o | output | 32 | Current program counter |
| wb_en_o | output | 1 | Current instruction commits a result at the next edge |
| wb_rd_o | output | 5 | Destination register of the current instruction |
| wb_data_o | output | 32 | Result of the current instruction |

## Verification
The hardest situation to reach from the ports is a fetch after the program counter has passed the end of the instruction store. At that point the same words execute a second time, against register contents that the first pass has changed. The stimulus fills all 64 words and runs 70 instructions, with a pause partway through. The tail of the run therefore wraps onto word 0. A reference model in the bench predicts every write-back from its own copy of the program and of the registers.

// File: rtl/rtype_pkg.sv
package rtype_pkg;
  localparam int unsigned XLEN   = 32;
  localparam int unsigned NREG   = 32;
  localparam int unsigned RF_AW  = $clog2(NREG);
  localparam int unsigned PC_STEP = XLEN / 8;

  localparam logic [5:0] OP_REG   = 6'h00;
  localparam logic [5:0] FN_ADD   = 6'h21;
  localparam logic [5:0] FN_SUB   = 6'h23;
  localparam logic [5:0] FN_OR    = 6'h25;

  typedef enum logic [1:0] {
    ALU_ADD = 2'd0,
    ALU_SUB = 2'd1,
    ALU_OR  = 2'd2
  } alu_sel_e;

  typedef struct packed {
    logic [5:0]       op;
    logic [RF_AW-1:0] rs;
    logic [RF_AW-1:0] rt;
    logic [RF_AW-1:0] rd;
    logic [4:0]       shamt;
    logic [5:0]       func;
  } rinst_t;
endpackage

// File: rtl/rtype_rst_sync.sv
module rtype_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/rtype_fetch.sv
module rtype_fetch
  import rtype_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            adv_i,
  input  logic            ld_en_i,
  input  logic [AW-1:0]   ld_addr_i,
  input  logic [XLEN-1:0] ld_data_i,
  output logic [XLEN-1:0] pc_o,
  output logic [XLEN-1:0] instr_o
);
  logic [XLEN-1:0] pc_q;
  logic [XLEN-1:0] pc_d;
  logic [XLEN-1:0] mem [DEPTH];

  always_comb begin
    pc_d = pc_q;
    if (adv_i) begin
      pc_d = pc_q + XLEN'(PC_STEP);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
    end else begin
      pc_q <= pc_d;
    end
  end

  always_ff @(posedge clk) begin
    if (ld_en_i) begin
      mem[ld_addr_i] <= ld_data_i;
    end
  end

  assign pc_o    = pc_q;
  assign instr_o = mem[pc_q[AW+1:2]];
endmodule

// File: rtl/rtype_decode.sv
module rtype_decode
  import rtype_pkg::*;
(
  input  logic [XLEN-1:0]  instr_i,
  output logic             valid_o,
  output alu_sel_e         alu_sel_o,
  output logic [RF_AW-1:0] rs_o,
  output logic [RF_AW-1:0] rt_o,
  output logic [RF_AW-1:0] rd_o
);
  rinst_t inst;
  logic   unused_shamt;

  assign inst         = rinst_t'(instr_i);
  assign unused_shamt = ^inst.shamt;

  always_comb begin
    valid_o   = 1'b0;
    alu_sel_o = ALU_ADD;
    if (inst.op == OP_REG) begin
      unique case (inst.func)
        FN_ADD: begin valid_o = 1'b1; alu_sel_o = ALU_ADD; end
        FN_SUB: begin valid_o = 1'b1; alu_sel_o = ALU_SUB; end
        FN_OR:  begin valid_o = 1'b1; alu_sel_o = ALU_OR;  end
        default: begin valid_o = 1'b0; alu_sel_o = ALU_ADD; end
      endcase
    end
  end

  assign rs_o = inst.rs;
  assign rt_o = inst.rt;
  assign rd_o = inst.rd;
endmodule

// File: rtl/rtype_alu.sv
module rtype_alu
  import rtype_pkg::*;
(
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  alu_sel_e        sel_i,
  output logic [XLEN-1:0] y_o
);
  logic [XLEN-1:0] sum;
  logic [XLEN-1:0] diff;
  logic [XLEN-1:0] orv;

  assign sum  = a_i + b_i;
  assign diff = a_i - b_i;
  assign orv  = a_i | b_i;

  always_comb begin
    unique case (sel_i)
      ALU_ADD: y_o = sum;
      ALU_SUB: y_o = diff;
      ALU_OR:  y_o = orv;
      default: y_o = sum;
    endcase
  end
endmodule

// File: rtl/rtype_regfile.sv
module rtype_regfile
  import rtype_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [RF_AW-1:0] waddr_i,
  input  logic [XLEN-1:0]  wdata_i,
  input  logic [RF_AW-1:0] raddr_a_i,
  input  logic [RF_AW-1:0] raddr_b_i,
  output logic [XLEN-1:0]  rdata_a_o,
  output logic [XLEN-1:0]  rdata_b_o
);
  logic [XLEN-1:0] regs [NREG];

  assign regs[0] = '0;

  for (genvar g = 1; g < NREG; g++) begin : g_reg
    logic en;
    assign en = we_i && (waddr_i == RF_AW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs[g] <= '0;
      end else if (en) begin
        regs[g] <= wdata_i;
      end
    end
  end

  assign rdata_a_o = regs[raddr_a_i];
  assign rdata_b_o = regs[raddr_b_i];
endmodule

// File: rtl/rtype_core.sv
module rtype_core
  import rtype_pkg::*;
#(
  parameter int unsigned IMEM_DEPTH = 64,
  localparam int unsigned AW = $clog2(IMEM_DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             ld_en_i,
  input  logic             ld_reg_i,
  input  logic [AW-1:0]    ld_addr_i,
  input  logic [XLEN-1:0]  ld_data_i,
  output logic [XLEN-1:0]  pc_o,
  output logic             wb_en_o,
  output logic [RF_AW-1:0] wb_rd_o,
  output logic [XLEN-1:0]  wb_data_o
);
  logic             rst_core_n;
  logic [XLEN-1:0]  instr;
  logic             dec_valid;
  alu_sel_e         alu_sel;
  logic [RF_AW-1:0] rs;
  logic [RF_AW-1:0] rt;
  logic [RF_AW-1:0] rd;
  logic [XLEN-1:0]  opa;
  logic [XLEN-1:0]  opb;
  logic [XLEN-1:0]  alu_y;
  logic             imem_ld;
  logic             rf_ld;
  logic             rf_we;
  logic [RF_AW-1:0] rf_waddr;
  logic [XLEN-1:0]  rf_wdata;

  rtype_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  assign imem_ld = !run_i && ld_en_i && !ld_reg_i;
  assign rf_ld   = !run_i && ld_en_i &&  ld_reg_i;

  rtype_fetch #(.DEPTH(IMEM_DEPTH)) u_fetch (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .adv_i     (run_i),
    .ld_en_i   (imem_ld),
    .ld_addr_i (ld_addr_i),
    .ld_data_i (ld_data_i),
    .pc_o      (pc_o),
    .instr_o   (instr)
  );

  rtype_decode u_dec (
    .instr_i   (instr),
    .valid_o   (dec_valid),
    .alu_sel_o (alu_sel),
    .rs_o      (rs),
    .rt_o      (rt),
    .rd_o      (rd)
  );

  rtype_alu u_alu (
    .a_i   (opa),
    .b_i   (opb),
    .sel_i (alu_sel),
    .y_o   (alu_y)
  );

  always_comb begin
    rf_we    = 1'b0;
    rf_waddr = rd;
    rf_wdata = alu_y;
    if (run_i) begin
      rf_we = dec_valid;
    end else if (rf_ld) begin
      rf_we    = 1'b1;
      rf_waddr = ld_addr_i[RF_AW-1:0];
      rf_wdata = ld_data_i;
    end
  end

  rtype_regfile u_rf (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .we_i      (rf_we),
    .waddr_i   (rf_waddr),
    .wdata_i   (rf_wdata),
    .raddr_a_i (rs),
    .raddr_b_i (rt),
    .rdata_a_o (opa),
    .rdata_b_o (opb)
  );

  assign wb_en_o   = run_i && dec_valid;
  assign wb_rd_o   = rd;
  assign wb_data_o = alu_y;
endmodule

// File: rtl/rtype_core_chk.sv
module rtype_core_chk (
  input logic        clk,
  input logic        rst_core_n,
  input logic        run,
  input logic [31:0] pc,
  input logic        wb_en,
  input logic [31:0] instr,
  input logic [31:0] opa,
  input logic [31:0] opb,
  input logic [31:0] wb_data
);
  assert_pc_step_R2: assert property (@(posedge clk) disable iff (!rst_core_n)
    run |=> pc == $past(pc) + 32'd4);
  assert_pc_hold_R2: assert property (@(posedge clk) disable iff (!rst_core_n)
    !run |=> pc == $past(pc));
  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_core_n)
    !run |-> !wb_en);
  assert_pc_align_R3: assert property (@(posedge clk) disable iff (!rst_core_n)
    pc[1:0] == 2'b00);
  assert_add_wrap_R4: assert property (@(posedge clk) disable iff (!rst_core_n)
    (wb_en && instr[5:0] == 6'h21) |-> wb_data == opa + opb);
  assert_sub_wrap_R5: assert property (@(posedge clk) disable iff (!rst_core_n)
    (wb_en && instr[5:0] == 6'h23) |-> wb_data == opa - opb);
  assert_or_R6: assert property (@(posedge clk) disable iff (!rst_core_n)
    (wb_en && instr[5:0] == 6'h25) |-> wb_data == (opa | opb));
  assert_unsup_op_R7: assert property (@(posedge clk) disable iff (!rst_core_n)
    (instr[31:26] != 6'h00) |-> !wb_en);
  assert_r0_zero_R8: assert property (@(posedge clk) disable iff (!rst_core_n)
    (wb_en && instr[25:21] == 5'd0 && instr[20:16] == 5'd0 && instr[5:0] == 6'h25)
      |-> wb_data == 32'd0);
endmodule

bind rtype_core rtype_core_chk u_chk (
  .clk        (clk),
  .rst_core_n (rst_core_n),
  .run        (run_i),
  .pc         (pc_o),
  .wb_en      (wb_en_o),
  .instr      (instr),
  .opa        (opa),
  .opb        (opb),
  .wb_data    (wb_data_o)
);

// File: tb/rtype_core_tb.sv
module rtype_core_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 64;
  localparam int AW = 6;

  logic        clk;
  logic        rst_n;
  logic        run_i;
  logic        ld_en_i;
  logic        ld_reg_i;
  logic [AW-1:0] ld_addr_i;
  logic [31:0] ld_data_i;
  logic [31:0] pc_o;
  logic        wb_en_o;
  logic [4:0]  wb_rd_o;
  logic [31:0] wb_data_o;

  rtype_core #(.IMEM_DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .run_i(run_i), .ld_en_i(ld_en_i),
    .ld_reg_i(ld_reg_i), .ld_addr_i(ld_addr_i), .ld_data_i(ld_data_i),
    .pc_o(pc_o), .wb_en_o(wb_en_o), .wb_rd_o(wb_rd_o), .wb_data_o(wb_data_o)
  );

  typedef struct {
    logic [31:0] pc;
    logic        en;
    logic [4:0]  rd;
    logic [31:0] data;
    string       req;
  } exp_t;

  exp_t        q[$];
  logic [31:0] mimem [DEPTH];
  logic [31:0] mreg [32];
  logic [31:0] mpc;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] enc(input logic [5:0] op, input int rs, input int rt,
                                      input int rd, input int sh, input logic [5:0] fn);
    return {op, 5'(rs), 5'(rt), 5'(rd), 5'(sh), fn};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic predict(input int n);
    for (int i = 0; i < n; i++) begin
      logic [31:0] w;
      exp_t e;
      w = mimem[mpc[AW+1:2]];
      e.pc = mpc;
      e.rd = w[15:11];
      e.en = (w[31:26] == 6'h00) &&
             (w[5:0] == 6'h21 || w[5:0] == 6'h23 || w[5:0] == 6'h25);
      case (w[5:0])
        6'h21:   e.data = mreg[w[25:21]] + mreg[w[20:16]];
        6'h23:   e.data = mreg[w[25:21]] - mreg[w[20:16]];
        default: e.data = mreg[w[25:21]] | mreg[w[20:16]];
      endcase
      if (!e.en)                e.req = "R7";
      else if (w[10:6] != 0)    e.req = "R9";
      else if (e.rd == 0)       e.req = "R8";
      else if (mpc >= 32'(DEPTH*4)) e.req = "R3";
      else if (w[5:0] == 6'h21) e.req = "R4/R11";
      else if (w[5:0] == 6'h23) e.req = "R5";
      else                      e.req = "R6";
      q.push_back(e);
      if (e.en && e.rd != 0) mreg[e.rd] = e.data;
      mpc += 32'd4;
    end
  endtask

  task automatic load(input bit to_reg, input int addr, input logic [31:0] data);
    @(negedge clk);
    ld_en_i = 1'b1; ld_reg_i = to_reg; ld_addr_i = AW'(addr); ld_data_i = data;
    @(negedge clk);
    ld_en_i = 1'b0;
  endtask

  task automatic run_for(input int n);
    predict(n);
    @(negedge clk);
    run_i = 1'b1;
    repeat (n) @(negedge clk);
    run_i = 1'b0;
  endtask

  // Scoreboard monitor: compares each committed instruction with the model
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (run_i) begin
        if (q.size() == 0) begin
          check(1'b0, "R2", pc_o, 32'hx);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(pc_o === e.pc, {"R2 pc ", e.req}, pc_o, e.pc);
          check(wb_en_o === e.en, e.req, {31'd0, wb_en_o}, {31'd0, e.en});
          if (e.en) begin
            check(wb_rd_o === e.rd, e.req, {27'd0, wb_rd_o}, {27'd0, e.rd});
            check(wb_data_o === e.data, e.req, wb_data_o, e.data);
          end
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; run_i = 1'b0; ld_en_i = 1'b0; ld_reg_i = 1'b0;
    ld_addr_i = '0; ld_data_i = '0;
    for (int i = 0; i < 32; i++) mreg[i] = 32'd0;
    mpc = 32'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #2;
    check(pc_o === 32'd0, "R1 pc", pc_o, 32'd0);
    check(wb_en_o === 1'b0, "R1 wb_en", {31'd0, wb_en_o}, 32'd0);

    // Program: fixed head, generated tail filling the whole store
    mimem[0] = enc(6'h00, 1, 2, 5, 0, 6'h21);  // add wraps to 0 (R4)
    mimem[1] = enc(6'h00, 0, 2, 6, 0, 6'h23);  // 0-1 wraps (R5)
    mimem[2] = enc(6'h00, 3, 4, 7, 0, 6'h25);  // or (R6)
    mimem[3] = enc(6'h00, 5, 7, 8, 0, 6'h21);  // back-to-back use (R11)
    mimem[4] = enc(6'h00, 1, 1, 0, 0, 6'h21);  // rd=0 (R8)
    mimem[5] = enc(6'h00, 0, 0, 9, 0, 6'h25);  // reads r0 (R8, R10)
    mimem[6] = enc(6'h01, 1, 2, 6, 0, 6'h21);  // bad op (R7)
    mimem[7] = enc(6'h00, 1, 2, 6, 0, 6'h20);  // bad func (R7)
    mimem[8] = enc(6'h00, 4, 2, 10, 31, 6'h21); // shamt ignored (R9)
    mimem[9] = enc(6'h00, 6, 0, 11, 0, 6'h25);  // r6 unchanged by R7 words
    for (int i = 10; i < DEPTH; i++) begin
      logic [5:0] fn;
      case (i % 4)
        0: fn = 6'h21;
        1: fn = 6'h23;
        2: fn = 6'h25;
        default: fn = 6'h27;
      endcase
      mimem[i] = enc(6'h00, (i*3) % 32, (i*7+1) % 32, (i*5+2) % 32, 0, fn);
    end
    for (int i = 0; i < DEPTH; i++) load(1'b0, i, mimem[i]);
    load(1'b1, 1, 32'hFFFF_FFFF); mreg[1] = 32'hFFFF_FFFF;
    load(1'b1, 2, 32'h0000_0001); mreg[2] = 32'h0000_0001;
    load(1'b1, 3, 32'h0F0F_0000); mreg[3] = 32'h0F0F_0000;
    load(1'b1, 4, 32'h1234_5678); mreg[4] = 32'h1234_5678;
    load(1'b1, 0, 32'hDEAD_BEEF);  // ignored (R10, R8)

    run_for(4);
    repeat (3) @(negedge clk);
    #2;
    check(pc_o === 32'd16, "R2 hold", pc_o, 32'd16);
    check(wb_en_o === 1'b0, "R2 idle", {31'd0, wb_en_o}, 32'd0);

    run_for(66);  // passes the end of the store and wraps (R3)
    #2;
    check(q.size() == 0, "R2 count", 32'(q.size()), 32'd0);
    check(pc_o === 32'd280, "R3 final pc", pc_o, 32'd280);

    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule